// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides which clocks of a small 8-bit microcontroller run. Software sets one of two request bits through a write strobe. The idle request stops only the processor clock, so timers, serial ports and interrupt logic keep working. The power-down request stops both the processor clock and the peripheral clock. The oscillator clock that feeds this block keeps running, so the controller can watch the wake pin.

Idle ends on any pending enabled interrupt. Power-down ends only when the external interrupt pin is enabled, configured level-sensitive, and held low for a parameterised number of consecutive oscillator cycles. The pin is first passed through a synchronizer. When the clocks come back, the block emits a one-cycle wake event, and the interrupt controller uses it to vector. Execution then returns to the instruction after the one that requested the low-power state.

Each clock gate samples its enable on the falling oscillator edge. The gated clock is the oscillator ANDed with that registered enable, so no shortened high phase can appear.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `idle_flag`, `pd_flag` and `wake_evt` are 0, and `cpu_clk` and `per_clk` both follow `osc_clk`.
- R2: In run mode, a write with `ctl_idle_set`=1 and `ctl_pd_set`=0 sets `idle_flag` at the next rising edge. From the following clock period, `cpu_clk` stays low and `per_clk` keeps toggling.
- R3: While `idle_flag`=1, `irq_any`=1 at a rising edge clears `idle_flag` and drives `wake_evt` high for exactly one cycle at that edge. `cpu_clk` resumes from the following period.
- R4: In run mode, a write with `ctl_pd_set`=1 sets `pd_flag` at the next rising edge. From the following period, both `cpu_clk` and `per_clk` stay low.
- R5: A write with both request bits at 1 enters power-down, not idle. `idle_flag` and `pd_flag` are never 1 together.
- R6: In power-down, `irq_any` is ignored. A low wake pin is also ignored when `xint_en`=0 or when `xint_level`=0 (0 means edge-configured, 1 means level-sensitive).
- R7: The wake pin passes through SYNC_STAGES (default 2) flops. Power-down ends at the edge where the synchronized pin has been seen low, with `xint_en`=`xint_level`=1, on WAKE_CYCLES (default 1024) consecutive edges. The pin is driven low before rising edge 1; `pd_flag` is still 1 after edge WAKE_CYCLES+1 and drops at edge WAKE_CYCLES+2. Any high sample restarts the count, so shorter lows never wake.
- R8: The power-down exit clears `pd_flag`, pulses `wake_evt` for exactly one cycle and restarts both clocks.
- R9: Control writes are ignored while idle or in power-down.
- R10: The gated clocks are never high while `osc_clk` is low.
- R11: An active-low reset in idle or in power-down returns the block to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the request bits |
| ctl_idle_set | input | 1 | Idle request bit of the write |
| ctl_pd_set | input | 1 | Power-down request bit of the write |
| irq_any | input | 1 | Some enabled interrupt is pending |
| xint_n | input | 1 | External interrupt pin, active low, asynchronous |
| xint_en | input | 1 | External interrupt enabled |
| xint_level | input | 1 | 1 = level-sensitive, 0 = edge-configured |
| cpu_clk | output | 1 | Gated processor clock |
| per_clk | output | 1 | Gated peripheral clock |
| idle_flag | output | 1 | Idle mode active |
| pd_flag | output | 1 | Power-down mode active |
| wake_evt | output | 1 | One-cycle pulse when clocks restart |

## Verification
A wrong mode state shows on the flags at the next rising edge, and on the gated clocks one half-period later. The bench compares both at every step. A wrong wake-counter value does not show until the pin is released or the count completes. For that reason the bench checks the exact exit edge after an uninterrupted low and also confirms that runs of WAKE_CYCLES-1 lows do not wake. It also applies disabled or edge-configured pin lows and pending internal interrupts during power-down, and checks that `pd_flag` stays 1.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  wake;
    } fsm_state_t;

    localparam int GATE_CPU = 0;
    localparam int GATE_PER = 1;
    localparam int NUM_GATES = 2;

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            assign sh_d = d_in;
        end else begin : g_chain
            assign sh_d = {sh_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
    parameter int COUNT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic low_in,
    output logic done
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;
    logic          hit;

    always_comb begin
        hit   = arm && low_in && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!arm || !low_in) begin
            cnt_d = '0;
        end else if (hit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = hit;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_idle,
    input  logic  wr_pd,
    input  logic  irq_any,
    input  logic  pd_wake,
    output mode_e mode,
    output logic  wake
);
    fsm_state_t s_d;
    fsm_state_t s_q;

    always_comb begin
        s_d      = s_q;
        s_d.wake = 1'b0;
        unique case (s_q.mode)
            MODE_RUN: begin
                if (wr_en) begin
                    if (wr_pd)        s_d.mode = MODE_PDOWN;
                    else if (wr_idle) s_d.mode = MODE_IDLE;
                end
            end
            MODE_IDLE: begin
                if (irq_any) begin
                    s_d.mode = MODE_RUN;
                    s_d.wake = 1'b1;
                end
            end
            MODE_PDOWN: begin
                if (pd_wake) begin
                    s_d.mode = MODE_RUN;
                    s_d.wake = 1'b1;
                end
            end
            default: s_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_RUN, wake: 1'b0};
        else        s_q <= s_d;
    end

    assign mode = s_q.mode;
    assign wake = s_q.wake;
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en,
    output logic [N-1:0] gclk
);
    logic [N-1:0] en_d;
    logic [N-1:0] en_q;

    always_comb en_d = en;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '1;
        else        en_q <= en_d;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_gate
            assign gclk[g] = clk & en_q[g];
        end
    endgenerate
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int WAKE_CYCLES = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_idle_set,
    input  logic ctl_pd_set,
    input  logic irq_any,
    input  logic xint_n,
    input  logic xint_en,
    input  logic xint_level,
    output logic cpu_clk,
    output logic per_clk,
    output logic idle_flag,
    output logic pd_flag,
    output logic wake_evt
);
    mode_e                mode;
    logic                 pin_s;
    logic                 pin_qual;
    logic                 pd_wake;
    logic [NUM_GATES-1:0] gate_en;
    logic [NUM_GATES-1:0] gate_clk;

    pmc_wake_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d_in  (xint_n),
        .q_out (pin_s)
    );

    assign pin_qual = xint_en && xint_level && !pin_s;

    pmc_wake_timer #(.COUNT(WAKE_CYCLES)) timer_i (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .arm    (mode == MODE_PDOWN),
        .low_in (pin_qual),
        .done   (pd_wake)
    );

    pmc_mode_fsm fsm_i (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_idle (ctl_idle_set),
        .wr_pd   (ctl_pd_set),
        .irq_any (irq_any),
        .pd_wake (pd_wake),
        .mode    (mode),
        .wake    (wake_evt)
    );

    always_comb begin
        gate_en           = '0;
        gate_en[GATE_CPU] = (mode == MODE_RUN);
        gate_en[GATE_PER] = (mode != MODE_PDOWN);
    end

    pmc_clk_gate #(.N(NUM_GATES)) gate_i (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .en    (gate_en),
        .gclk  (gate_clk)
    );

    assign cpu_clk   = gate_clk[GATE_CPU];
    assign per_clk   = gate_clk[GATE_PER];
    assign idle_flag = (mode == MODE_IDLE);
    assign pd_flag   = (mode == MODE_PDOWN);
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic osc_clk,
    input logic rst_n,
    input logic ctl_wr,
    input logic ctl_idle_set,
    input logic ctl_pd_set,
    input logic irq_any,
    input logic xint_en,
    input logic xint_level,
    input logic idle_flag,
    input logic pd_flag,
    input logic wake_evt
);
    logic in_run;
    assign in_run = !idle_flag && !pd_flag;

    AST_MODE_EXCLUSIVE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $onehot0({idle_flag, pd_flag})); // R5

    AST_PD_PRIORITY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        in_run && ctl_wr && ctl_pd_set |=> pd_flag && !idle_flag); // R5

    AST_IDLE_ENTRY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        in_run && ctl_wr && ctl_idle_set && !ctl_pd_set |=> idle_flag); // R2

    AST_IDLE_EXIT: assert property (@(posedge osc_clk) disable iff (!rst_n)
        idle_flag && irq_any |=> !idle_flag && wake_evt); // R3

    AST_IDLE_HOLD: assert property (@(posedge osc_clk) disable iff (!rst_n)
        idle_flag && !irq_any |=> idle_flag && !pd_flag); // R9

    AST_PD_NO_EXT_EN: assert property (@(posedge osc_clk) disable iff (!rst_n)
        pd_flag && !xint_en |=> pd_flag); // R6

    AST_PD_EDGE_CFG: assert property (@(posedge osc_clk) disable iff (!rst_n)
        pd_flag && !xint_level |=> pd_flag); // R6

    AST_WAKE_SINGLE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt); // R8

    AST_WAKE_FROM_LP: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(wake_evt) |-> $past(idle_flag || pd_flag) && in_run); // R8
endmodule

bind pwr_mode_ctrl pmc_checker chk_i (
    .osc_clk      (osc_clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_idle_set (ctl_idle_set),
    .ctl_pd_set   (ctl_pd_set),
    .irq_any      (irq_any),
    .xint_en      (xint_en),
    .xint_level   (xint_level),
    .idle_flag    (idle_flag),
    .pd_flag      (pd_flag),
    .wake_evt     (wake_evt)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
    localparam int W = 1024;
    localparam int NVEC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, ctl_idle_set = 1'b0, ctl_pd_set = 1'b0, irq_any = 1'b0;
    logic xint_n = 1'b1, xint_en = 1'b1, xint_level = 1'b1;
    logic cpu_clk, per_clk, idle_flag, pd_flag, wake_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.WAKE_CYCLES(W), .SYNC_STAGES(2)) dut_i (
        .osc_clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_idle_set(ctl_idle_set),
        .ctl_pd_set(ctl_pd_set), .irq_any(irq_any), .xint_n(xint_n), .xint_en(xint_en),
        .xint_level(xint_level), .cpu_clk(cpu_clk), .per_clk(per_clk),
        .idle_flag(idle_flag), .pd_flag(pd_flag), .wake_evt(wake_evt)
    );

    // {wr, idle_set, pd_set, irq, exp_idle, exp_pd, exp_wake}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0000_000,  // R1 quiet after reset
        7'b1100_100,  // R2 enter idle
        7'b1010_100,  // R9 write ignored in idle
        7'b0001_001,  // R3 interrupt ends idle
        7'b0000_000,  // R3 wake pulse is one cycle
        7'b1110_010,  // R5 both bits: power-down wins
        7'b0001_010,  // R6 interrupt ignored in power-down
        7'b1100_010   // R9 write ignored in power-down
    };
    localparam int VREQ [NVEC] = '{1, 2, 9, 3, 3, 5, 6, 9};

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(logic wr, logic iset, logic pset, logic irq);
        @(negedge clk);
        ctl_wr = wr; ctl_idle_set = iset; ctl_pd_set = pset; irq_any = irq;
        @(posedge clk); #1;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pin_low(int n);
        @(negedge clk);
        xint_n = 1'b0;
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
        xint_n = 1'b1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "idle_flag in reset", int'(idle_flag), 0);
        chk("R1", "pd_flag in reset", int'(pd_flag), 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "cpu_clk after reset", int'(cpu_clk), 1);
        chk("R1", "per_clk after reset", int'(per_clk), 1);
        @(negedge clk); #1;
        chk("R10", "cpu_clk with osc low", int'(cpu_clk), 0);
        chk("R10", "per_clk with osc low", int'(per_clk), 0);

        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][6], VEC[v][5], VEC[v][4], VEC[v][3]);
            chk($sformatf("R%0d", VREQ[v]), $sformatf("vector %0d flags", v),
                int'({idle_flag, pd_flag, wake_evt}), int'(VEC[v][2:0]));
        end

        // R4: both clocks stopped in power-down
        tick(1);
        chk("R4", "cpu_clk in power-down", int'(cpu_clk), 0);
        chk("R4", "per_clk in power-down", int'(per_clk), 0);

        // R7: short low does not wake
        pin_low(W - 1);
        tick(4);
        chk("R7", "pd after short low", int'(pd_flag), 1);
        // R7: a high sample restarts the count
        pin_low(W - 1);
        pin_low(W - 1);
        tick(4);
        chk("R7", "pd after split low", int'(pd_flag), 1);
        // R6: edge-configured pin ignored
        xint_level = 1'b0;
        pin_low(W + 4);
        tick(4);
        chk("R6", "pd with edge config", int'(pd_flag), 1);
        // R6: disabled pin ignored
        xint_level = 1'b1; xint_en = 1'b0;
        pin_low(W + 4);
        tick(4);
        chk("R6", "pd with pin disabled", int'(pd_flag), 1);
        xint_en = 1'b1;
        tick(4);

        // R7/R8: exact exit edge
        @(negedge clk);
        xint_n = 1'b0;
        for (int i = 0; i < W + 1; i++) @(posedge clk);
        #1;
        chk("R7", "pd one edge before exit", int'(pd_flag), 1);
        chk("R7", "no wake before exit", int'(wake_evt), 0);
        @(posedge clk); #1;
        chk("R8", "pd cleared at exit", int'(pd_flag), 0);
        chk("R8", "wake pulse at exit", int'(wake_evt), 1);
        @(posedge clk); #1;
        chk("R8", "wake pulse ends", int'(wake_evt), 0);
        @(posedge clk); #1;
        chk("R8", "cpu_clk restarted", int'(cpu_clk), 1);
        chk("R8", "per_clk restarted", int'(per_clk), 1);
        @(negedge clk) xint_n = 1'b1;

        // R2: idle gating
        step(1'b1, 1'b1, 1'b0, 1'b0);
        tick(1);
        chk("R2", "cpu_clk in idle", int'(cpu_clk), 0);
        chk("R2", "per_clk in idle", int'(per_clk), 1);
        // R11: reset from idle
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R11", "idle cleared by reset", int'(idle_flag), 0);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset from power-down
        step(1'b1, 1'b0, 1'b1, 1'b0);
        tick(1);
        chk("R4", "pd entered", int'(pd_flag), 1);
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R11", "pd cleared by reset", int'(pd_flag), 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R11", "cpu_clk after reset in pd", int'(cpu_clk), 1);
        chk("R11", "per_clk after reset in pd", int'(per_clk), 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule